// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Node

This block is one stage of a serial priority chain. Several interrupt sources share one active-low, open-drain request line. Each stage receives a priority-in signal from the stage above it and passes a priority-out signal to the stage below. A stage latches the rising edge of its peripheral's request. It pulls the shared line low only when nothing above it is asking for service or being served. While it is pending or being served, it holds its own priority-out low, so stages further down stay quiet.

The stage watches decoded CPU bus strobes. During an interrupt-acknowledge cycle, the stage that has priority and a pending request places its vector on the data bus. In the same cycle it becomes the stage under service. It then keeps the chain below it blocked until it sees the two-byte return-from-interrupt opcode fetched while it holds priority. An I/O write to the peripheral-reset address clears every stage at once.

Stages are connected output-to-input. The first stage's priority input is tied high.

Top module: `irq_chain_node`

## Requirements
- R1: After reset, no request is driven, no vector is driven, and priority-out follows priority-in.
- R2: A low-to-high transition of the peripheral request input sets a pending flag. Holding the input high does not set it again after it has been cleared.
- R3: Priority-out is 0 whenever the stage is pending or under service. Otherwise it equals priority-in in the same cycle, with no clock in the path.
- R4: A pending stage drives the request line only while priority-in is 1. With priority-in at 0 it holds off, and it drives once priority-in returns to 1.
- R5: In a cycle with acknowledge high, priority-in 1 and a pending request, the stage drives its 8-bit vector with the vector-enable high. At the following edge it becomes under service, clears pending and releases the request line.
- R6: A stage with priority-in 0, or with nothing pending, does not respond to an acknowledge cycle (vector-enable stays 0).
- R7: Service ends at the edge of an instruction fetch of byte 0x4D that follows a fetch of 0xED. This applies only while the stage is under service with priority-in 1. Non-fetch cycles between the two bytes are allowed. A fetch of any byte other than 0xED or 0x4D after 0xED cancels the match, and a repeated 0xED keeps it.
- R8: A new request that arrives during service stays pending without driving the line, and the line is driven once service ends. A higher-priority stage can still request and be acknowledged while a lower one is under service.
- R9: An I/O write to address 0xF8FF clears pending and under-service and releases the line. I/O writes to other addresses have no effect.
- R10: The request pin is open drain: it is 0 while the stage drives a request and high-impedance otherwise, never 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req_i | input | 1 | Peripheral request, edge-captured |
| pri_in_i | input | 1 | Priority from the stage above (1 = free) |
| pri_out_o | output | 1 | Priority to the stage below |
| fetch_i | input | 1 | Instruction-fetch strobe, one cycle per byte |
| ack_i | input | 1 | Interrupt-acknowledge strobe |
| io_wr_i | input | 1 | I/O write strobe |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus data (fetched opcodes) |
| vec_o | output | DATA_W | Vector driven during a taken acknowledge |
| vec_oe_o | output | 1 | Vector enable |
| irq_drive_o | output | 1 | High while the stage pulls the request line |
| irq_n_o | output | 1 | Open-drain request pin (0 or Z) |

## Verification
A three-stage chain is exercised with these patterns:
- Simultaneous requests, which show that acknowledges follow chain order and not arrival order.
- A higher stage interrupting while a lower one is in service, which separates correct nesting from a stage that ignores priority-in at acknowledge or at return.
- Opcode sequences with a foreign byte and with idle gaps between 0xED and 0x4D, which separate a true two-fetch match from a single-byte or any-cycle detector.
- Re-requests during service, acknowledges with no eligible stage, and reset writes to the matching and to a neighbouring address, which cover deferral, non-response and address decoding.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned OPC_W      = 8;
  localparam logic [OPC_W-1:0] RET_PREFIX = 8'hED;
  localparam logic [OPC_W-1:0] RET_SUFFIX = 8'h4D;

  typedef enum logic [0:0] {
    SNP_IDLE   = 1'b0,
    SNP_PREFIX = 1'b1
  } snoop_state_t;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture (
  input  logic clk,
  input  logic rst,
  input  logic dev_req_i,
  input  logic take_i,
  input  logic disarm_i,
  output logic pending_o
);
  logic req_q;
  logic rise;

  assign rise = dev_req_i & ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      req_q <= dev_req_i;
      if (disarm_i)
        pending_o <= 1'b0;
      else
        pending_o <= (pending_o & ~take_i) | rise;
    end
  end
endmodule

// File: rtl/irq_ret_snoop.sv
module irq_ret_snoop
  import irq_chain_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] PREFIX = DATA_W'(RET_PREFIX),
  parameter logic [DATA_W-1:0] SUFFIX = DATA_W'(RET_SUFFIX)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ret_o
);
  snoop_state_t st_q, st_d;
  logic is_pre, is_suf;

  assign is_pre = (data_i == PREFIX);
  assign is_suf = (data_i == SUFFIX);
  assign ret_o  = fetch_i & (st_q == SNP_PREFIX) & is_suf;

  always_comb begin
    st_d = st_q;
    if (fetch_i)
      st_d = is_pre ? SNP_PREFIX : SNP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SNP_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/irq_service_track.sv
module irq_service_track (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  logic ret_i,
  input  logic pri_in_i,
  input  logic disarm_i,
  output logic in_service_o
);
  always_ff @(posedge clk) begin
    if (rst || disarm_i)
      in_service_o <= 1'b0;
    else if (take_i)
      in_service_o <= 1'b1;
    else if (ret_i && pri_in_i)
      in_service_o <= 1'b0;
  end
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [DATA_W-1:0] VECTOR = '0,
  parameter logic [ADDR_W-1:0] DISARM_ADDR = 16'hF8FF
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_req_i,
  input  logic              pri_in_i,
  output logic              pri_out_o,
  input  logic              fetch_i,
  input  logic              ack_i,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_oe_o,
  output logic              irq_drive_o,
  output wire               irq_n_o
);
  logic pending, in_service, take, ret_seen, disarm;

  assign disarm = io_wr_i & (addr_i == DISARM_ADDR);
  assign take   = ack_i & pri_in_i & pending & ~in_service;

  irq_req_capture u_capture (
    .clk       (clk),
    .rst       (rst),
    .dev_req_i (dev_req_i),
    .take_i    (take),
    .disarm_i  (disarm),
    .pending_o (pending)
  );

  irq_ret_snoop #(.DATA_W(DATA_W)) u_snoop (
    .clk     (clk),
    .rst     (rst),
    .fetch_i (fetch_i),
    .data_i  (data_i),
    .ret_o   (ret_seen)
  );

  irq_service_track u_service (
    .clk          (clk),
    .rst          (rst),
    .take_i       (take),
    .ret_i        (ret_seen),
    .pri_in_i     (pri_in_i),
    .disarm_i     (disarm),
    .in_service_o (in_service)
  );

  assign pri_out_o   = pri_in_i & ~(pending | in_service);
  assign irq_drive_o = pending & pri_in_i & ~in_service;
  assign irq_n_o     = irq_drive_o ? 1'b0 : 1'bz;
  assign vec_oe_o    = take;
  assign vec_o       = take ? VECTOR : '0;
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DISARM_ADDR = 16'hF8FF
)(
  input logic              clk,
  input logic              rst,
  input logic              pri_in_i,
  input logic              pri_out_o,
  input logic              ack_i,
  input logic              io_wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              vec_oe_o,
  input logic              irq_drive_o
);
  logic wipe;
  assign wipe = io_wr_i && (addr_i == DISARM_ADDR);

  // R5
  take_release_chk: assert property (@(posedge clk) disable iff (rst)
    vec_oe_o |=> !irq_drive_o);

  // R3
  service_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_oe_o && !wipe) |=> !pri_out_o);

  // R6
  vec_needs_pri_chk: assert property (@(posedge clk) disable iff (rst)
    vec_oe_o |-> (ack_i && pri_in_i));

  // R4
  drive_needs_pri_chk: assert property (@(posedge clk) disable iff (rst)
    irq_drive_o |-> pri_in_i);

  // R9
  wipe_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (!irq_drive_o && (pri_out_o == pri_in_i)));
endmodule

bind irq_chain_node irq_chain_node_chk #(
  .ADDR_W      (ADDR_W),
  .DISARM_ADDR (DISARM_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pri_in_i    (pri_in_i),
  .pri_out_o   (pri_out_o),
  .ack_i       (ack_i),
  .io_wr_i     (io_wr_i),
  .addr_i      (addr_i),
  .vec_oe_o    (vec_oe_o),
  .irq_drive_o (irq_drive_o)
);

// File: tb/test_irq_chain_node.sv
module test_irq_chain_node;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic top_pri = 1'b1;
  logic [N-1:0] req = '0;
  logic fetch = 1'b0, ack = 1'b0, io_wr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;

  logic [N:0]   pri;
  logic [N-1:0] drive, vec_oe;
  logic [7:0]   vec [N];

  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  always #4 clk = ~clk;
  assign pri[0] = top_pri;

  for (genvar g = 0; g < N; g++) begin : g_node
    wire irq_n_w;
    irq_chain_node #(.VECTOR(8'(8'h10 * (g + 1)))) i_irq_chain_node (
      .clk (clk), .rst (rst), .dev_req_i (req[g]),
      .pri_in_i (pri[g]), .pri_out_o (pri[g+1]),
      .fetch_i (fetch), .ack_i (ack), .io_wr_i (io_wr),
      .addr_i (addr), .data_i (data),
      .vec_o (vec[g]), .vec_oe_o (vec_oe[g]),
      .irq_drive_o (drive[g]), .irq_n_o (irq_n_w)
    );
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chain(input string tag, input logic [N-1:0] e_drv, input logic [N-1:0] e_pri);
    chk(drive == e_drv, {tag, " drive"}, int'(drive), int'(e_drv));
    chk(pri[N:1] == e_pri, {tag, " pri_out"}, int'(pri[N:1]), int'(e_pri));
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_ack(input int e);
    exp_q.push_back(e);
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic fetch_byte(input logic [7:0] b);
    fetch = 1'b1; data = b; cyc(); fetch = 1'b0; data = 8'h00;
  endtask

  task automatic reti();
    fetch_byte(8'hED); fetch_byte(8'h4D);
  endtask

  task automatic retrigger(input int i);
    req[i] = 1'b0; cyc(); req[i] = 1'b1; cyc();
  endtask

  task automatic io_write(input logic [15:0] a);
    io_wr = 1'b1; addr = a; cyc(); io_wr = 1'b0; addr = '0;
  endtask

  // scoreboard monitor: one expected item per acknowledge cycle
  initial forever begin
    @(negedge clk);
    if (ack) begin
      int e, hits;
      logic [7:0] bus;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
      hits = $countones(vec_oe);
      bus = '0;
      for (int k = 0; k < N; k++) if (vec_oe[k]) bus |= vec[k];
      if (e < 0) chk(hits == 0, "R6 no responder", hits, 0);
      else chk(hits == 1 && int'(bus) == e, "R5 vector order", int'(bus), e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chain("R1 reset", 3'b000, 3'b111);
    chk(vec_oe == 0, "R1 vec idle", int'(vec_oe), 0);

    req[1] = 1'b1; cyc();
    chain("R2 capture", 3'b010, 3'b001);
    chk(g_node[1].irq_n_w === 1'b0, "R10 pin low", int'(g_node[1].irq_n_w), 0);
    chk(g_node[0].irq_n_w !== 1'b1, "R10 never high", int'(g_node[0].irq_n_w), 0);

    req[0] = 1'b1; req[2] = 1'b1; cyc();
    chain("R4 held off", 3'b001, 3'b000);

    do_ack(8'h10);
    chain("R5 released", 3'b000, 3'b000);

    fetch_byte(8'hED); fetch_byte(8'h00); fetch_byte(8'h4D);
    chain("R7 cancel", 3'b000, 3'b000);

    fetch_byte(8'hED); cyc(); fetch_byte(8'h4D);
    chain("R7 gap end", 3'b010, 3'b001);

    do_ack(8'h20);
    chain("R5 second", 3'b000, 3'b001);

    retrigger(0);
    chain("R8 nested req", 3'b001, 3'b000);
    do_ack(8'h10);
    chain("R8 nested svc", 3'b000, 3'b000);

    reti();
    chain("R7 inner only", 3'b000, 3'b001);
    fetch_byte(8'hED); fetch_byte(8'hED); fetch_byte(8'h4D);
    chain("R7 double prefix", 3'b100, 3'b011);

    do_ack(8'h30);
    chain("R5 third", 3'b000, 3'b011);

    retrigger(2);
    chain("R8 deferred", 3'b000, 3'b011);
    reti();
    chain("R8 reasserted", 3'b100, 3'b011);
    do_ack(8'h30);
    reti();
    chain("R2 no retrigger", 3'b000, 3'b111);

    do_ack(-1);
    chain("R6 idle ack", 3'b000, 3'b111);

    retrigger(0);
    do_ack(8'h10);
    retrigger(1);
    chain("R9 setup", 3'b000, 3'b000);
    io_write(16'hF8FE);
    chain("R9 other addr", 3'b000, 3'b000);
    io_write(16'hF8FF);
    chain("R9 disarm", 3'b000, 3'b111);
    do_ack(-1);

    cyc();
    chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule